// File: doc/BRIEF.md
# Enabled Two-Bit Counter with Terminal-Count Flags

This block is a small synchronous counter held in a two-bit state register. At each rising clock edge it looks at a single enable input. When the enable is low the count holds. When it is high the count steps up by one, and from the top value it wraps back to zero. The count is driven straight from the state bits.

Three flags mark the terminal value, which is binary 11. The first is combinational and depends on both the state and the live enable: it is high only in the cycle whose edge will wrap the count. The second depends on the state alone: it is high for as long as the count sits at 11. The third is taken directly from a flip-flop. Its input logic looks at the next state and the enable one cycle ahead, so the flag never glitches inside a clock period and is valid soon after the edge.

A synchronous active-high reset returns the count to zero and clears the flag register. No flag is shown while reset is high.

Top module: `tcnt_top`

## Requirements
- R1: The count output equals the state bits. The state after a reset edge is 00, and the count takes the values 00, 01, 10 and 11 as it advances.
- R2: When `en` is 0 at a rising edge with `rst` low, the count keeps its previous value.
- R3: When `en` is 1 at a rising edge with `rst` low, the count increments by one, and 11 becomes 00.
- R4: `tc_mealy` is 1 exactly when the count is 11 and `en` is 1 in the same cycle with `rst` low. Otherwise it is 0.
- R5: `tc_moore` is 1 exactly when the count is 11 with `rst` low, whatever the value of `en`.
- R6: `tc_pipe` comes from a register. After an edge with `rst` low, it is 1 exactly when the new count is 11 and `en` was 1 at that edge. That is, it carries the enable-gated terminal flag of the new state, evaluated with the enable that was registered with it.
- R7: A rising edge with `rst` high sets the count to 00 and `tc_pipe` to 0, regardless of `en`.
- R8: While `rst` is high, `tc_mealy` and `tc_moore` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, sampled at the rising edge |
| count | output | 2 | Current state, which is the count value |
| tc_mealy | output | 1 | Terminal flag gated by the live enable |
| tc_moore | output | 1 | Terminal flag decoded from the state only |
| tc_pipe | output | 1 | Registered enable-gated terminal flag |

## Verification
Reset and the wrap can fall in the same cycle. In that cycle the count is 11 and the enable is high, so the Mealy flag would announce a wrap, while reset overrides both the step and the flag register. The bench drives this case directly: it raises `rst` while the count sits at 11 and `en` is high. It then checks that both combinational flags are 0 in that cycle, and that the count and `tc_pipe` both read zero after the edge, rather than the wrapped value with a set flag. Random runs with a high reset density also create this case many more times.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;

    localparam int unsigned TC_W = 2;

    typedef logic [TC_W-1:0] tc_count_t;

    localparam tc_count_t TC_ZERO = '0;
    localparam tc_count_t TC_TERM = '1;

    typedef struct packed {
        tc_count_t count;
        logic      pipe;
    } tc_regs_t;

endpackage

// File: rtl/tcnt_step.sv
module tcnt_step
    import tcnt_pkg::*;
(
    input  tc_count_t cur,
    input  logic      en,
    output tc_count_t nxt,
    output logic      at_term
);

    always_comb begin
        at_term = (cur == TC_TERM);
        if (en) begin
            nxt = cur + tc_count_t'(1);
        end else begin
            nxt = cur;
        end
    end

endmodule

// File: rtl/tcnt_flags.sv
module tcnt_flags (
    input  logic at_term,
    input  logic en,
    input  logic rst,
    output logic mealy,
    output logic moore
);

    always_comb begin
        moore = at_term & ~rst;
        mealy = at_term & en & ~rst;
    end

endmodule

// File: rtl/tcnt_top.sv
module tcnt_top
    import tcnt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    output logic [TC_W-1:0] count,
    output logic            tc_mealy,
    output logic            tc_moore,
    output logic            tc_pipe
);

    tc_regs_t  regs_d;
    tc_regs_t  regs_q;
    tc_count_t step_nxt;
    logic      cur_term;

    tcnt_step u_step (
        .cur     (regs_q.count),
        .en      (en),
        .nxt     (step_nxt),
        .at_term (cur_term)
    );

    tcnt_flags u_flags (
        .at_term (cur_term),
        .en      (en),
        .rst     (rst),
        .mealy   (tc_mealy),
        .moore   (tc_moore)
    );

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.count = TC_ZERO;
            regs_d.pipe  = 1'b0;
        end else begin
            regs_d.count = step_nxt;
            regs_d.pipe  = (step_nxt == TC_TERM) & en;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign count   = regs_q.count;
    assign tc_pipe = regs_q.pipe;

endmodule

// File: rtl/tcnt_checker.sv
module tcnt_checker
    import tcnt_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            en,
    input logic [TC_W-1:0] count,
    input logic            tc_mealy,
    input logic            tc_moore,
    input logic            tc_pipe
);

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> (count == $past(count)));

    a_r3_step_and_wrap: assert property (@(posedge clk) disable iff (rst)
        en |=> (count == tc_count_t'($past(count) + tc_count_t'(1))));

    a_r4_mealy_needs_enable: assert property (@(posedge clk) disable iff (rst)
        tc_mealy == (tc_moore && en));

    a_r5_moore_at_top: assert property (@(posedge clk) disable iff (rst)
        tc_moore == (count == TC_TERM));

    a_r6_pipe_matches_prior_enable: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (tc_pipe == ($past(en) && (count == TC_TERM))));

    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> ((count == TC_ZERO) && !tc_pipe));

    a_r8_quiet_in_reset: assert property (@(posedge clk)
        rst |-> (!tc_mealy && !tc_moore));

endmodule

bind tcnt_top tcnt_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .count    (count),
    .tc_mealy (tc_mealy),
    .tc_moore (tc_moore),
    .tc_pipe  (tc_pipe)
);

// File: tb/tcnt_top_bench.sv
module tcnt_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [1:0] count;
    logic       tc_mealy;
    logic       tc_moore;
    logic       tc_pipe;

    int         checks = 0;
    int         fails  = 0;
    logic [1:0] m_cnt  = 2'b00;
    logic       m_pipe = 1'b0;
    bit         m_known = 1'b0;

    always #4 clk = ~clk;

    tcnt_top u_tcnt_top (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .count    (count),
        .tc_mealy (tc_mealy),
        .tc_moore (tc_moore),
        .tc_pipe  (tc_pipe)
    );

    function automatic logic [1:0] ref_next(input logic [1:0] c, input logic e);
        return e ? c + 2'd1 : c;
    endfunction

    function automatic logic ref_mealy(input logic [1:0] c, input logic e, input logic r);
        return (c == 2'b11) && e && !r;
    endfunction

    function automatic logic ref_moore(input logic [1:0] c, input logic r);
        return (c == 2'b11) && !r;
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check mid-low phase, update model at rising edge.
    task automatic step(input logic r, input logic e);
        @(negedge clk);
        rst = r;
        en  = e;
        #1;
        if (m_known) begin
            check("R1/R2/R3 count", count, m_cnt);
            check("R6/R7 tc_pipe", {1'b0, tc_pipe}, {1'b0, m_pipe});
            check("R4/R8 tc_mealy", {1'b0, tc_mealy}, {1'b0, ref_mealy(m_cnt, e, r)});
            check("R5/R8 tc_moore", {1'b0, tc_moore}, {1'b0, ref_moore(m_cnt, r)});
        end else if (r) begin
            check("R8 tc_mealy in reset", {1'b0, tc_mealy}, 2'b00);
            check("R8 tc_moore in reset", {1'b0, tc_moore}, 2'b00);
        end
        @(posedge clk);
        if (r) begin
            m_cnt  = 2'b00;
            m_pipe = 1'b0;
            m_known = 1'b1;
        end else if (m_known) begin
            m_pipe = (ref_next(m_cnt, e) == 2'b11) && e;
            m_cnt  = ref_next(m_cnt, e);
        end
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20130417);
        // R7 / R1: reset state
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        // R3: walk to the top value, R6 sets on arrival at 11
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        // R2 / R5: hold at 11 with enable low, Moore high, Mealy low
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        // R4: Mealy high at 11 with enable, then R3 wrap to 00
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        // climb back to 11, then reset together with enable at the top value (R7, R8)
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        // R6: arrive at 11 with enable, then hold: pipe must drop
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            logic r_v;
            logic e_v;
            r_v = ($urandom % 16) == 0;
            e_v = ($urandom % 4) != 0;
            step(r_v, e_v);
        end
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
        end
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule